// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Sequencer

This block is the digital control of a small 8-bit successive-approximation converter that talks to a host over a three-wire serial port made of chip select, serial clock and data lines. It runs on a fast system clock and oversamples the serial clock, so every serial event is detected as a rising or falling edge of `sclk`. While `cs_n` is low it hunts for a start bit on `sdi`. It then takes three setup bits: input mode, channel swap and tail format. From these it drives the analog input selection, opens a sampling window, and walks a binary search using an external comparator. Each resolved bit is sent on `sdo` as soon as it is decided.

The analog parts sit outside the block: the sample-and-hold, the capacitor array and the comparator. The block presents its current trial code on `trial_code` and reads the comparator decision on `cmp_in`, where 1 means the held input is at or above the trial code. All ports are plain control and data pins, and no port uses a valid/ready stream. The serial port has no back-pressure, because the host owns the serial clock and each edge is one step. Raising `cs_n` ends any transfer at once and asserts `pwr_down`.

Top module: `sar_adc_seq`

## Requirements
- R1: After `cs_n` falls, every 0 on `sdi` at an `sclk` rising edge is ignored. The first 1 is the start bit, and no sampling or output activity happens before it.
- R2: The three rising edges after the start bit capture, in this order: input mode (1 = single-ended), swap, and tail format (1 = zero tail).
- R3: Source codes on `pos_sel`/`neg_sel` are 0 = ground, 1 = input A, 2 = input B. In single-ended mode, swap 0 gives A/ground and swap 1 gives B/ground. In differential mode, swap 0 gives A/B and swap 1 gives B/A. Both pins read 0 until the swap bit is taken.
- R4: `sample_en` rises on the rising edge that takes the swap bit. It falls on the first falling edge after the tail-format bit, so the window lasts 1.5 serial clocks.
- R5: On the falling edge that closes the window, `sdo_oe` goes to 1 and `sdo` sends a 0 null bit. Before that falling edge, `sdo_oe` is 0 and `sdo` is 0.
- R6: At the close of the window, `trial_code` becomes 0x80. On each of the next 8 falling edges, the bit under test is kept when `cmp_in` is 1 and cleared when it is 0, and the next lower bit is set. After the 8th step, `trial_code` holds the result.
- R7: The 8 falling edges after the null bit send result bits 7 down to 0 on `sdo`.
- R8: With tail format 1, `sdo` sends 0 on every falling edge after bit 0 for as long as `cs_n` stays low.
- R9: With tail format 0, the 7 falling edges after bit 0 send result bits 1 up to 7, and 0s follow after that.
- R10: Once the tail-format bit is taken, `sdi` has no effect on the transfer, the selection or the result until `cs_n` goes high again.
- R11: One system clock after `cs_n` is high, the block drives `sdo_oe` = 0, `pwr_down` = 1, `sample_en` = 0, both selections to 0 and `trial_code` to 0, aborting any transfer. After that, a new transfer starts from the start-bit hunt.
- R12: After reset, `pwr_down` = 1, `sdo_oe` = 0, `sdo` = 0, `sample_en` = 0 and `trial_code` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `sclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low; high aborts and powers down |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, taken on `sclk` rising edges |
| cmp_in | input | 1 | Comparator decision: 1 when input is at or above `trial_code` |
| pos_sel | output | 2 | Positive input source (0 ground, 1 A, 2 B) |
| neg_sel | output | 2 | Negative input source (0 ground, 1 A, 2 B) |
| sample_en | output | 1 | Sample-and-hold tracking window |
| trial_code | output | 8 | Current trial code for the capacitor array |
| sdo | output | 1 | Serial data out, changes on `sclk` falling edges |
| sdo_oe | output | 1 | Output enable for `sdo` (0 = high impedance) |
| pwr_down | output | 1 | Power-down request to the analog section |

## Verification
The hardest state to reach is the trailing part of a transfer, where the least-significant-first copy has to come out of the final register in the right order. Reaching it takes a start bit, three setup bits, a closed window and eight comparator decisions that all agree with one input value. The bench models the comparator as a comparison of its own chosen input value against `trial_code`, so every search converges on a value that is known in advance. It also holds `sdi` at 1 through conversion and the tail, and drops `cs_n` in the middle of a search to show that the next transfer starts clean.

// File: rtl/sar_adc_seq_pkg.sv
package sar_adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_MODE,
    ST_SWAP,
    ST_SAMP_CFG,
    ST_SAMP_END,
    ST_CONV,
    ST_TAIL
  } seq_state_t;

  localparam logic [1:0] SRC_GND = 2'd0;
  localparam logic [1:0] SRC_A   = 2'd1;
  localparam logic [1:0] SRC_B   = 2'd2;

endpackage

// File: rtl/sclk_edge.sv
module sclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/src_decode.sv
module src_decode
  import sar_adc_seq_pkg::*;
(
  input  logic       valid,
  input  logic       single,
  input  logic       swap,
  output logic [1:0] pos_sel,
  output logic [1:0] neg_sel
);
  always_comb begin
    pos_sel = SRC_GND;
    neg_sel = SRC_GND;
    if (valid) begin
      pos_sel = swap ? SRC_B : SRC_A;
      if (single) neg_sel = SRC_GND;
      else        neg_sel = swap ? SRC_A : SRC_B;
    end
  end
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             step,
  input  logic             cmp_in,
  output logic [NBITS-1:0] trial,
  output logic             last_step
);
  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial <= '0;
      mask  <= '0;
    end else if (clr) begin
      trial <= '0;
      mask  <= '0;
    end else if (load) begin
      trial <= TOP_BIT;
      mask  <= TOP_BIT;
    end else if (step && (mask != '0)) begin
      trial <= (cmp_in ? trial : (trial & ~mask)) | (mask >> 1);
      mask  <= mask >> 1;
    end
  end

  assign last_step = mask[0];
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_seq_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             cmp_in,
  output logic [1:0]       pos_sel,
  output logic [1:0]       neg_sel,
  output logic             sample_en,
  output logic [NBITS-1:0] trial_code,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             pwr_down
);
  localparam int IDXW = $clog2(NBITS + 1);
  localparam logic [IDXW-1:0] IDX_END = IDXW'(NBITS);

  seq_state_t       state;
  logic             rise, fall;
  logic             single_q, swap_q, zero_tail_q, sel_valid;
  logic [IDXW-1:0]  tail_idx;
  logic             last_step;
  logic             sar_load, sar_step;
  logic [NBITS-1:0] tail_shift;

  sclk_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk),
    .rise  (rise),
    .fall  (fall)
  );

  src_decode u_dec (
    .valid   (sel_valid),
    .single  (single_q),
    .swap    (swap_q),
    .pos_sel (pos_sel),
    .neg_sel (neg_sel)
  );

  assign sar_load = !cs_n && (state == ST_SAMP_END) && fall;
  assign sar_step = !cs_n && (state == ST_CONV) && fall;

  sar_reg #(.NBITS(NBITS)) u_sar (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cs_n),
    .load      (sar_load),
    .step      (sar_step),
    .cmp_in    (cmp_in),
    .trial     (trial_code),
    .last_step (last_step)
  );

  assign tail_shift = trial_code >> tail_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      single_q    <= 1'b0;
      swap_q      <= 1'b0;
      zero_tail_q <= 1'b0;
      sel_valid   <= 1'b0;
      sample_en   <= 1'b0;
      sdo         <= 1'b0;
      sdo_oe      <= 1'b0;
      pwr_down    <= 1'b1;
      tail_idx    <= '0;
    end else if (cs_n) begin
      state       <= ST_IDLE;
      single_q    <= 1'b0;
      swap_q      <= 1'b0;
      zero_tail_q <= 1'b0;
      sel_valid   <= 1'b0;
      sample_en   <= 1'b0;
      sdo         <= 1'b0;
      sdo_oe      <= 1'b0;
      pwr_down    <= 1'b1;
      tail_idx    <= '0;
    end else begin
      pwr_down <= 1'b0;
      unique case (state)
        ST_IDLE: state <= ST_HUNT;
        ST_HUNT: if (rise && sdi) state <= ST_MODE;
        ST_MODE: if (rise) begin
          single_q <= sdi;
          state    <= ST_SWAP;
        end
        ST_SWAP: if (rise) begin
          swap_q    <= sdi;
          sel_valid <= 1'b1;
          sample_en <= 1'b1;
          state     <= ST_SAMP_CFG;
        end
        ST_SAMP_CFG: if (rise) begin
          zero_tail_q <= sdi;
          state       <= ST_SAMP_END;
        end
        ST_SAMP_END: if (fall) begin
          sample_en <= 1'b0;
          sdo_oe    <= 1'b1;
          sdo       <= 1'b0;
          state     <= ST_CONV;
        end
        ST_CONV: if (fall) begin
          sdo <= cmp_in;
          if (last_step) begin
            tail_idx <= IDXW'(1);
            state    <= ST_TAIL;
          end
        end
        ST_TAIL: if (fall) begin
          if (!zero_tail_q && (tail_idx < IDX_END)) sdo <= tail_shift[0];
          else                                      sdo <= 1'b0;
          if (tail_idx < IDX_END) tail_idx <= tail_idx + IDXW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk
  import sar_adc_seq_pkg::*;
#(
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic [1:0]       pos_sel,
  input logic [1:0]       neg_sel,
  input logic             sample_en,
  input logic [NBITS-1:0] trial_code,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             pwr_down
);
  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!sdo_oe && pwr_down && !sample_en && trial_code == '0));

  p_null_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (sdo == 1'b0 && !sample_en));

  p_quiet_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  p_first_trial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (trial_code == TOP_BIT));

  p_sel_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> ((pos_sel == SRC_A || pos_sel == SRC_B) && neg_sel != pos_sel));

  p_window_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_en) && !$past(cs_n)) |-> sdo_oe);
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .pos_sel    (pos_sel),
  .neg_sel    (neg_sel),
  .sample_en  (sample_en),
  .trial_code (trial_code),
  .sdo        (sdo),
  .sdo_oe     (sdo_oe),
  .pwr_down   (pwr_down)
);

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic [7:0] vin = 8'h00;
  logic       cmp_in;
  logic [1:0] pos_sel, neg_sel;
  logic       sample_en, sdo, sdo_oe, pwr_down;
  logic [7:0] trial_code;
  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  assign cmp_in = (vin >= trial_code);

  sar_adc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cmp_in(cmp_in), .pos_sel(pos_sel), .neg_sel(neg_sel),
    .sample_en(sample_en), .trial_code(trial_code), .sdo(sdo),
    .sdo_oe(sdo_oe), .pwr_down(pwr_down)
  );

  // {vin, single, swap, zero_tail, leading zeros}
  localparam logic [12:0] VEC [8] = '{
    {8'hA5, 1'b1, 1'b0, 1'b1, 2'd0},
    {8'h3C, 1'b1, 1'b1, 1'b0, 2'd2},
    {8'h00, 1'b0, 1'b0, 1'b0, 2'd1},
    {8'hFF, 1'b0, 1'b1, 1'b1, 2'd3},
    {8'h81, 1'b1, 1'b0, 1'b0, 2'd0},
    {8'h7E, 1'b0, 1'b1, 1'b0, 2'd2},
    {8'h01, 1'b0, 1'b0, 1'b1, 2'd1},
    {8'h6B, 1'b1, 1'b1, 1'b0, 2'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic srise(input logic b);
    sdi = b;
    @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sfall();
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input logic [7:0] v, input logic sg, input logic sw,
                     input logic zt, input logic [1:0] nz);
    logic [1:0] ep, en;
    vin = v;
    ep = sw ? 2'd2 : 2'd1;
    en = sg ? 2'd0 : (sw ? 2'd1 : 2'd2);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 pwr_down low while selected", pwr_down, 1'b0);
    for (int i = 0; i < nz; i++) begin
      srise(1'b0); sfall();
      chk("R1 leading zero ignored (sample_en)", sample_en, 1'b0);
      chk("R1 leading zero ignored (oe)", sdo_oe, 1'b0);
    end
    srise(1'b1); sfall();
    chk("R1 start bit, no window yet", sample_en, 1'b0);
    srise(sg); sfall();
    chk("R3 selection idle before swap bit", pos_sel, 2'd0);
    srise(sw);
    chk("R4 window opens on swap bit", sample_en, 1'b1);
    chk("R2 R3 pos_sel", pos_sel, ep);
    chk("R2 R3 neg_sel", neg_sel, en);
    chk("R5 output off before null", sdo_oe, 1'b0);
    sfall();
    chk("R4 window still open", sample_en, 1'b1);
    srise(zt);
    chk("R4 window open at format bit", sample_en, 1'b1);
    sfall();
    chk("R4 window closed", sample_en, 1'b0);
    chk("R5 oe at null", sdo_oe, 1'b1);
    chk("R5 null bit", sdo, 1'b0);
    chk("R6 first trial", trial_code, 8'h80);
    for (int i = 7; i >= 0; i--) begin
      srise(1'b1); sfall();   // R10: sdi held high during conversion
      chk($sformatf("R7 result bit %0d", i), sdo, v[i]);
    end
    chk("R6 final trial_code is result", trial_code, v);
    for (int j = 1; j <= 10; j++) begin
      srise(1'b1); sfall();
      if (zt) chk($sformatf("R8 zero tail %0d", j), sdo, 1'b0);
      else    chk($sformatf("R9 lsb-first tail %0d", j), sdo, (j <= 7) ? v[j] : 1'b0);
    end
    chk("R10 selection unchanged by late sdi", {pos_sel, neg_sel}, {ep, en});
    chk("R10 result unchanged by late sdi", trial_code, v);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 oe off", sdo_oe, 1'b0);
    chk("R11 pwr_down", pwr_down, 1'b1);
    chk("R11 selection cleared", {pos_sel, neg_sel}, 4'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 pwr_down at reset", pwr_down, 1'b1);
    chk("R12 oe at reset", sdo_oe, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 sdo after reset", sdo, 1'b0);
    chk("R12 sample_en after reset", sample_en, 1'b0);
    chk("R12 trial after reset", trial_code, 8'h00);

    for (int k = 0; k < 8; k++)
      run(VEC[k][12:5], VEC[k][4], VEC[k][3], VEC[k][2], VEC[k][1:0]);

    // R11: abort in the middle of a search, then a clean transfer
    vin = 8'hC3;
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    srise(1'b1); sfall();
    srise(1'b0); sfall();
    srise(1'b1); sfall();
    srise(1'b0); sfall();
    srise(1'b0); sfall();
    srise(1'b0); sfall();
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 abort oe", sdo_oe, 1'b0);
    chk("R11 abort window", sample_en, 1'b0);
    chk("R11 abort trial", trial_code, 8'h00);
    chk("R11 abort pwr_down", pwr_down, 1'b1);
    repeat (2) @(negedge clk);
    run(8'h5A, 1'b0, 1'b0, 1'b0, 2'd0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule